// File: doc/BRIEF.md
# Conversion Control Sequencer

This block is the digital control core of a sigma-delta converter. It decides when the modulator and decimation filter run, when they are held in reset, and when a finished result may be written to the data register. It supports free-running conversion, one-shot conversion, synchronisation to an external strobe, a pin-level reset and a power-down state. Filter settling is modelled as a fixed number of master-clock cycles, set by `SETTLE_CYC`. Once the filter has settled in free-running mode, each per-sample strobe from the filter model produces one data update.

Three asynchronous pins come in through two-flop synchronisers: a synchronisation input that holds the filter in reset while low, an active-low reset and an active-low power-down. Because every path from a pin to the filter has a fixed latency, several instances that share a master clock and a common synchronisation signal update their data within one cycle of each other. A single configuration write port sets the operating mode, an output-enable bit and two general-purpose output levels. The block reports a ready flag, a not-yet-steady flag and a power-down flag.

Top module: `conv_seq`

## Requirements
- R1: While system reset `rst` is high and after it falls, the mode reads 001 (free-running), `gpo` is 00, `rdy` and `stdy` are 1, `stby`, `flt_rst` and `data_upd` are 0.
- R2: Each pin passes through two flops. `flt_rst` is still 0 one clock edge after `sync_pin` falls and is 1 after the second edge. It stays 1 while the synchronised sync input or synchronised reset pin is low.
- R3: The first update after a hold is a one-cycle `data_upd` pulse with fixed latency. It comes `SETTLE_CYC` edges after `rst` falls or after a mode write is accepted, and `SETTLE_CYC`+2 edges after a pin is released. There is no update before that point.
- R4: In mode 001, once the filter has settled, a `sample_stb` sampled high at an edge gives `data_upd` high for the following cycle only.
- R5: Writing mode 010 starts one conversion. After `SETTLE_CYC` edges `data_upd` pulses once, and in that same cycle the mode reads back 000. Later sample strobes cause no update.
- R6: While the synchronised sync input is low, no `data_upd` occurs, even when `sample_stb` is high, and `rdy` is 1.
- R7: Mode 011 or `standby_pin_n` low (after synchronisation) drives `stby` to 1, forces `rdy` and `stdy` to 1 and blocks updates. Configuration writes are still accepted, and a pin-driven power-down leaves the stored mode unchanged.
- R8: After power-down ends, `rdy` and `stdy` stay 1 until the next `data_upd`.
- R9: While the synchronised reset pin is low, configuration returns to defaults, writes are ignored, `rdy`=1 and `flt_rst`=1. After release the first update comes `SETTLE_CYC`+2 edges later.
- R10: `reg_wdata` fields: [2:0] mode, [3] output enable, [5:4] output levels. With enable 1, `gpo` equals the stored levels; with enable 0, `gpo` is 00. `stby` reflects mode 011.
- R11: Every `data_upd` cycle shows `rdy`=0 and `stdy`=0. `rdy` goes back to 1 on an accepted write or any hold.
- R12: Mode 000, and any code with bit 2 set, is idle: no update occurs and `flt_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high system reset |
| sync_pin | input | 1 | Asynchronous sync input; low holds the filter in reset |
| reset_pin_n | input | 1 | Asynchronous active-low reset pin |
| standby_pin_n | input | 1 | Asynchronous active-low power-down pin |
| reg_wr | input | 1 | Configuration write strobe |
| reg_wdata | input | 6 | Configuration word (mode, enable, levels) |
| sample_stb | input | 1 | Per-sample strobe from the filter model |
| rdy | output | 1 | Ready flag, 0 once new data is written |
| stdy | output | 1 | Filter-not-steady flag |
| stby | output | 1 | Power-down active |
| flt_rst | output | 1 | Filter and modulator reset |
| data_upd | output | 1 | Data register update strobe |
| gpo | output | 2 | General-purpose output pins |
| cur_mode | output | 3 | Stored mode field |

## Verification
The same settling counter is restarted by five different routes: system reset, a sync pin release, a reset pin release, a power-down pin release and a mode write. The first update is timed to the exact edge for each route, so the two-cycle synchroniser offset separates the pin routes from the register routes. Sample strobes are applied in three states: settled free-running, post-single-shot idle and during holds. This separates the streaming path from the one-shot path and from the hold gating. Random configuration words mixed with directed writes confirm the field positions and the output-pin gating.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int MODE_W = 3;
    localparam int GPO_W  = 2;
    localparam int CFG_W  = MODE_W + 1 + GPO_W;

    typedef enum logic [MODE_W-1:0] {
        MD_IDLE   = 3'b000,
        MD_CONT   = 3'b001,
        MD_SINGLE = 3'b010,
        MD_STBY   = 3'b011
    } mode_e;

    typedef struct packed {
        logic [GPO_W-1:0] lvl;
        logic             oe;
        mode_e            mode;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{lvl: '0, oe: 1'b0, mode: MD_CONT};

    function automatic logic mode_runs(mode_e m);
        return (m == MD_CONT) || (m == MD_SINGLE);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= pin_in[i];
                sync_q <= meta_q;
            end
        end
        assign pin_out[i] = sync_q;
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic stream_en,
    input  logic sample_stb,
    output logic done_evt
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          settled_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q     <= CW'(SETTLE_CYC);
            settled_q <= 1'b0;
        end else if (!settled_q) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1))
                settled_q <= 1'b1;
        end
    end

    always_comb begin
        done_evt = 1'b0;
        if (!hold) begin
            if (!settled_q)
                done_evt = (cnt_q == CW'(1));
            else
                done_evt = stream_en && sample_stb;
        end
    end
endmodule

// File: rtl/cfg_reg.sv
module cfg_reg
    import conv_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_acc,
    input  cfg_t wdata,
    input  logic single_done,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_DEFAULT;
        else if (wr_acc)
            cfg_q <= wdata;
        else if (single_done)
            cfg_q.mode <= MD_IDLE;
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_pin,
    input  logic              reset_pin_n,
    input  logic              standby_pin_n,
    input  logic              reg_wr,
    input  logic [CFG_W-1:0]  reg_wdata,
    input  logic              sample_stb,
    output logic              rdy,
    output logic              stdy,
    output logic              stby,
    output logic              flt_rst,
    output logic              data_upd,
    output logic [GPO_W-1:0]  gpo,
    output logic [MODE_W-1:0] cur_mode
);
    logic [2:0] pins_s;
    logic       s_sync, s_rst_n, s_stby_n;
    logic       pin_rst, wr_acc, hold, done_evt, single_done;
    cfg_t       cfg_q;

    pin_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_in  ({standby_pin_n, reset_pin_n, sync_pin}),
        .pin_out (pins_s)
    );

    assign s_sync   = pins_s[0];
    assign s_rst_n  = pins_s[1];
    assign s_stby_n = pins_s[2];

    assign pin_rst     = !s_rst_n;
    assign flt_rst     = !s_sync || pin_rst;
    assign wr_acc      = reg_wr && !pin_rst;
    assign stby        = (cfg_q.mode == MD_STBY) || !s_stby_n;
    assign hold        = flt_rst || stby || !mode_runs(cfg_q.mode) || wr_acc;
    assign single_done = done_evt && (cfg_q.mode == MD_SINGLE);

    cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst || pin_rst),
        .wr_acc      (wr_acc),
        .wdata       (cfg_t'(reg_wdata)),
        .single_done (single_done),
        .cfg_q       (cfg_q)
    );

    settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .stream_en  (cfg_q.mode == MD_CONT),
        .sample_stb (sample_stb),
        .done_evt   (done_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy      <= 1'b1;
            stdy     <= 1'b1;
            data_upd <= 1'b0;
        end else begin
            data_upd <= done_evt;
            if (flt_rst || stby || wr_acc)
                rdy <= 1'b1;
            else if (done_evt)
                rdy <= 1'b0;
            if (pin_rst || stby)
                stdy <= 1'b1;
            else if (done_evt)
                stdy <= 1'b0;
        end
    end

    assign gpo      = cfg_q.oe ? cfg_q.lvl : '0;
    assign cur_mode = cfg_q.mode;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk
    import conv_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rdy,
    input logic              stdy,
    input logic              stby,
    input logic              flt_rst,
    input logic              data_upd,
    input logic [GPO_W-1:0]  gpo,
    input logic [MODE_W-1:0] cur_mode,
    input logic              pin_rst
);
    // R11: a data update always shows both flags low
    assert_upd_flags_R11: assert property (@(posedge clk) disable iff (rst)
        data_upd |-> (!rdy && !stdy));

    // R6: a filter hold suppresses the next update
    assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        flt_rst |=> !data_upd);

    // R7: sustained power-down keeps both flags high
    assert_stby_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (stby && $past(stby)) |-> (rdy && stdy));

    // R5: one-shot completion drops back to idle
    assert_single_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (data_upd && $past(cur_mode) == MD_SINGLE) |-> (cur_mode == MD_IDLE));

    // R12: idle mode produces no update
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(cur_mode) == MD_IDLE) |-> !data_upd);

    // R9: a held reset pin restores defaults
    assert_pin_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (pin_rst && $past(pin_rst)) |-> (cur_mode == MD_CONT && gpo == '0 && rdy && flt_rst));
endmodule

bind conv_seq conv_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rdy      (rdy),
    .stdy     (stdy),
    .stby     (stby),
    .flt_rst  (flt_rst),
    .data_upd (data_upd),
    .gpo      (gpo),
    .cur_mode (cur_mode),
    .pin_rst  (pin_rst)
);

// File: tb/conv_seq_tb.sv
module conv_seq_tb;
    localparam int S = 20;

    logic       clk = 1'b0;
    logic       rst, sync_pin, reset_pin_n, standby_pin_n, reg_wr, sample_stb;
    logic [5:0] reg_wdata;
    logic       rdy, stdy, stby, flt_rst, data_upd;
    logic [1:0] gpo;
    logic [2:0] cur_mode;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    conv_seq #(.SETTLE_CYC(S)) u_dut (
        .clk(clk), .rst(rst), .sync_pin(sync_pin), .reset_pin_n(reset_pin_n),
        .standby_pin_n(standby_pin_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .sample_stb(sample_stb), .rdy(rdy), .stdy(stdy), .stby(stby),
        .flt_rst(flt_rst), .data_upd(data_upd), .gpo(gpo), .cur_mode(cur_mode)
    );

    function automatic int exp_gpo(logic [5:0] d);
        return d[3] ? int'(d[5:4]) : 0;
    endfunction

    function automatic int exp_stby(logic [5:0] d);
        return (d[2:0] == 3'b011) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [5:0] d);
        reg_wdata = d;
        reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic wait_exact(int n, string req, bit chk_stdy);
        int bad = 0;
        for (int i = 0; i < n - 1; i++) begin
            tick();
            if (data_upd || !rdy || (chk_stdy && !stdy)) bad++;
        end
        chk({req, " early update or flag drop"}, bad, 0);
        tick();
        chk({req, " update on exact edge"}, int'(data_upd), 1);
        chk({req, " R11 rdy low at update"}, int'(rdy), 0);
        chk({req, " R11 stdy low at update"}, int'(stdy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad;
        logic [5:0] d;
        void'($urandom(32'd4711));
        rst = 1'b1; sync_pin = 1'b1; reset_pin_n = 1'b1; standby_pin_n = 1'b1;
        reg_wr = 1'b0; reg_wdata = '0; sample_stb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", int'(cur_mode), 1);
        chk("R1 gpo", int'(gpo), 0);
        chk("R1 rdy", int'(rdy), 1);
        chk("R1 stdy", int'(stdy), 1);
        chk("R1 stby", int'(stby), 0);
        chk("R1 flt_rst", int'(flt_rst), 0);
        chk("R1 data_upd", int'(data_upd), 0);
        rst = 1'b0;
        wait_exact(S, "R3 after system reset", 1'b1);

        // R4 streaming
        sample_stb = 1'b1;
        tick();
        sample_stb = 1'b0;
        chk("R4 strobe gives update", int'(data_upd), 1);
        tick();
        chk("R4 pulse one cycle", int'(data_upd), 0);

        // R2 / R6 sync hold
        sync_pin = 1'b0;
        tick();
        chk("R2 flt_rst after one edge", int'(flt_rst), 0);
        tick();
        chk("R2 flt_rst after two edges", int'(flt_rst), 1);
        sample_stb = 1'b1;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (data_upd || !flt_rst) bad++;
        end
        chk("R6 no update while sync low", bad, 0);
        chk("R6 rdy high while sync low", int'(rdy), 1);
        sample_stb = 1'b0;
        sync_pin = 1'b1;
        wait_exact(S + 2, "R3 sync release", 1'b0);

        // R12 idle codes
        wr(6'b000000);
        sample_stb = 1'b1;
        bad = 0;
        for (int i = 0; i < S + 4; i++) begin
            tick();
            if (data_upd || flt_rst) bad++;
        end
        chk("R12 idle 000 quiet", bad, 0);
        wr(6'b000110);
        bad = 0;
        for (int i = 0; i < S + 4; i++) begin
            tick();
            if (data_upd || flt_rst) bad++;
        end
        chk("R12 idle 110 quiet", bad, 0);
        sample_stb = 1'b0;

        // R5 single shot
        wr(6'b000010);
        chk("R5 mode single after write", int'(cur_mode), 2);
        chk("R11 rdy set by write", int'(rdy), 1);
        wait_exact(S, "R5 single shot", 1'b0);
        chk("R5 back to idle", int'(cur_mode), 0);
        sample_stb = 1'b1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (data_upd || cur_mode != 3'b000) bad++;
        end
        sample_stb = 1'b0;
        chk("R5 no further updates", bad, 0);

        // R7 / R8 register power-down
        wr(6'b000001);
        wait_exact(S, "R3 mode write continuous", 1'b0);
        wr(6'b011011);
        chk("R7 stby from mode", int'(stby), 1);
        chk("R10 gpo readable in power-down", int'(gpo), 1);
        tick();
        chk("R7 rdy forced", int'(rdy), 1);
        chk("R7 stdy forced", int'(stdy), 1);
        sample_stb = 1'b1;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (data_upd) bad++;
        end
        sample_stb = 1'b0;
        chk("R7 no update in power-down", bad, 0);
        wr(6'b011001);
        chk("R7 stby cleared", int'(stby), 0);
        wait_exact(S, "R8 flags held after mode power-down", 1'b1);

        // R7 / R8 pin power-down
        standby_pin_n = 1'b0;
        tick();
        tick();
        chk("R7 stby from pin", int'(stby), 1);
        chk("R7 mode kept under pin power-down", int'(cur_mode), 1);
        wr(6'b101001);
        chk("R7 write accepted in power-down", int'(gpo), 2);
        tick();
        chk("R7 stdy forced by pin", int'(stdy), 1);
        standby_pin_n = 1'b1;
        wait_exact(S + 2, "R8 pin power-down release", 1'b1);

        // R9 reset pin
        wr(6'b111001);
        chk("R10 gpo levels", int'(gpo), 3);
        reset_pin_n = 1'b0;
        tick();
        tick();
        chk("R9 flt_rst", int'(flt_rst), 1);
        tick();
        chk("R9 mode default", int'(cur_mode), 1);
        chk("R9 gpo default", int'(gpo), 0);
        chk("R9 rdy", int'(rdy), 1);
        wr(6'b111000);
        tick();
        chk("R9 write ignored mode", int'(cur_mode), 1);
        chk("R9 write ignored gpo", int'(gpo), 0);
        reset_pin_n = 1'b1;
        wait_exact(S + 2, "R9 reset pin release", 1'b1);

        // R10 random configuration words
        for (int i = 0; i < 40; i++) begin
            d = 6'($urandom);
            wr(d);
            chk("R10 mode field", int'(cur_mode), int'(d[2:0]));
            chk("R10 gpo", int'(gpo), exp_gpo(d));
            chk("R10 stby", int'(stby), exp_stby(d));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule